// File: doc/BRIEF.md
# Receiver Controller SPI Command Decoder

This block is the SPI slave of a serial data receiver controller. A host lowers an active-low chip select and clocks an 8-bit command code in on the data input, most significant bit first. Depending on the command, data bits then flow in or out, also MSB first. The number of data bits is fixed by the command.

The block holds the 16-bit control register and the 8-bit clock divide register. It issues the following actions to the surrounding controller:
- writes and bulk fills of the label acceptance table;
- reads of that table, bit by bit;
- pops from the receive word buffer;
- a master reset pulse.

It also reads the buffer status flags. On a buffer read, it can reverse the 8 label bits of the word. The table storage, the buffer and the line receiver sit outside this block.

The SPI pins are sampled in the system clock domain through a synchronizer. The serial clock must therefore be several times slower than the system clock; a half period of at least four system clocks is enough.

Words are popped from the buffer through a valid/ready pair with these rules:
- `rx_word_ready` is raised for exactly one system cycle, in the cycle the pop command's code completes, and only if `rx_word_valid` is high.
- The word on `rx_word_data` is taken in that same cycle.
- If `rx_word_valid` is low at that moment, no handshake takes place and zeros are returned.
- The buffer must hold `rx_word_data` stable while `rx_word_valid` is high.

Top module: `rxctl_spi_regs`

## Requirements
- R1: After reset the control register and the divide register are 0 and `spi_miso_oe` is low.
- R2: Code 0x10 followed by 16 data bits loads the control register. Code 0x0B shifts the control register out as 16 bits, MSB first.
- R3: Code 0x07 followed by 8 data bits loads the divide register. Code 0x0C shifts it out as 8 bits.
- R4: Code 0x0A shifts out an 8-bit status byte. Bit 0 is buffer empty, bit 1 is half full and bit 2 is full; bits 3 to 7 read 0.
- R5: Code 0x08 pops exactly one word when the buffer offers one and shifts it out as 32 bits, MSB first. The low byte of the word is the label.
- R6: When control bit 11 is 1, the label bits of a popped word come out as stored. When it is 0, label bit 0 is swapped with bit 7, bit 1 with bit 6, and so on.
- R7: Code 0x08 on an empty buffer returns 32 zero bits and makes no handshake.
- R8: Code 0x02 clears every table entry and code 0x03 sets every entry. Each acts once the 8th code bit arrives, with chip select still low.
- R9: Code 0x04 clears, and code 0x05 sets, the single table entry addressed by the 8 data bits that follow.
- R10: Code 0x06 writes each following data bit to the table, starting at entry 0xFF and going down. Code 0x0D shifts the table out in the same order.
- R11: Code 0x01 emits one `master_reset` pulse and leaves the control register unchanged.
- R12: If chip select rises before a control, divide or single-entry write is complete, that write does not happen.
- R13: Codes 0x00, 0x09, 0x0E, 0x0F and all undefined codes change no register, pop nothing and touch no table entry.
- R14: `spi_miso_oe` is low while chip select is high and high during a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad; the pad floats when low |
| rx_word_valid | input | 1 | Buffer has a word to give |
| rx_word_ready | output | 1 | One-cycle pop request |
| rx_word_data | input | 32 | Word at the head of the buffer |
| fifo_empty | input | 1 | Buffer empty flag |
| fifo_half | input | 1 | Buffer at least half full |
| fifo_full | input | 1 | Buffer full flag |
| lbl_rd_addr | output | 8 | Table entry being read |
| lbl_rd_bit | input | 1 | Value of the addressed table entry |
| lbl_wr_en | output | 1 | Single-entry table write strobe |
| lbl_wr_addr | output | 8 | Table entry to write |
| lbl_wr_val | output | 1 | Value to write |
| lbl_fill_en | output | 1 | Whole-table fill strobe |
| lbl_fill_val | output | 1 | Value for the whole-table fill |
| master_reset | output | 1 | One-cycle master reset pulse |
| ctrl_reg | output | 16 | Control register |
| aclk_div | output | 8 | Clock divide register |

## Verification
A bit counter that is off by one shows up right away: the next read returns its data shifted by one position, and a write loads a register with shifted data. A latched command code that is wrong shows up within the same frame. Either the wrong register changes, or an action pulse appears that the bench's count of pops, resets and table entries does not expect. A stale table address pointer only shows up after a bulk write or dump, as entries at the wrong positions in the bench's table model. A chip-select abort that fails to clear state corrupts the frame that follows.

// File: rtl/rxctl_spi_pkg.sv
package rxctl_spi_pkg;
  typedef enum logic [7:0] {
    CMD_NOP        = 8'h00,
    CMD_MRESET     = 8'h01,
    CMD_TBL_CLRALL = 8'h02,
    CMD_TBL_SETALL = 8'h03,
    CMD_TBL_CLR1   = 8'h04,
    CMD_TBL_SET1   = 8'h05,
    CMD_TBL_BULK   = 8'h06,
    CMD_DIV_WR     = 8'h07,
    CMD_POP        = 8'h08,
    CMD_STAT_RD    = 8'h0A,
    CMD_CTRL_RD    = 8'h0B,
    CMD_DIV_RD     = 8'h0C,
    CMD_TBL_DUMP   = 8'h0D,
    CMD_CTRL_WR    = 8'h10
  } cmd_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic si_o
);
  // each stage holds {sck, cs_n, si}; one extra stage feeds edge detection
  localparam logic [2:0] IDLE = 3'b010;
  logic [STAGES:0][2:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {(STAGES+1){IDLE}};
    else        stg <= {stg[STAGES-1:0], {sck_i, csn_i, si_i}};
  end

  assign sck_rise = stg[STAGES-1][2] & ~stg[STAGES][2];
  assign sck_fall = ~stg[STAGES-1][2] & stg[STAGES][2];
  assign cs_act   = ~stg[STAGES-1][1];
  assign si_o     = stg[STAGES-1][0];
endmodule

// File: rtl/label_order.sv
module label_order #(
  parameter int WORDW = 32,
  parameter int LBLW  = 8
) (
  input  logic [WORDW-1:0] word_i,
  input  logic             keep,
  output logic [WORDW-1:0] word_o
);
  logic [LBLW-1:0] flipped;

  for (genvar b = 0; b < LBLW; b++) begin : g_flip
    assign flipped[b] = word_i[LBLW-1-b];
  end

  assign word_o = keep ? word_i : {word_i[WORDW-1:LBLW], flipped};
endmodule

// File: rtl/rxctl_spi_regs.sv
module rxctl_spi_regs
  import rxctl_spi_pkg::*;
#(
  parameter int OPW         = 8,
  parameter int CTRLW       = 16,
  parameter int DIVW        = 8,
  parameter int WORDW       = 32,
  parameter int LBLAW       = 8,
  parameter int STATW       = 8,
  parameter int ORDER_BIT   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  input  logic             rx_word_valid,
  output logic             rx_word_ready,
  input  logic [WORDW-1:0] rx_word_data,
  input  logic             fifo_empty,
  input  logic             fifo_half,
  input  logic             fifo_full,
  output logic [LBLAW-1:0] lbl_rd_addr,
  input  logic             lbl_rd_bit,
  output logic             lbl_wr_en,
  output logic [LBLAW-1:0] lbl_wr_addr,
  output logic             lbl_wr_val,
  output logic             lbl_fill_en,
  output logic             lbl_fill_val,
  output logic             master_reset,
  output logic [CTRLW-1:0] ctrl_reg,
  output logic [DIVW-1:0]  aclk_div
);
  localparam int NLBL = 1 << LBLAW;
  localparam int CNTW = $clog2(OPW + NLBL + 1);
  localparam int SRW  = CTRLW;
  localparam logic [CNTW-1:0] C_OP_LAST  = CNTW'(OPW - 1);
  localparam logic [CNTW-1:0] C_DATA0    = CNTW'(OPW);
  localparam logic [CNTW-1:0] C_ADDR_END = CNTW'(OPW + LBLAW - 1);
  localparam logic [CNTW-1:0] C_DIV_END  = CNTW'(OPW + DIVW - 1);
  localparam logic [CNTW-1:0] C_CTRL_END = CNTW'(OPW + CTRLW - 1);
  localparam logic [CNTW-1:0] C_BULK_END = CNTW'(OPW + NLBL);
  localparam logic [CNTW-1:0] C_MAX      = '1;

  logic sck_rise, sck_fall, cs_act, si_s;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .csn_i(spi_cs_n), .si_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .si_o(si_s)
  );

  logic [WORDW-1:0] popped;

  label_order #(.WORDW(WORDW), .LBLW(LBLAW)) u_order (
    .word_i(rx_word_data), .keep(ctrl_reg[ORDER_BIT]), .word_o(popped)
  );

  logic [CNTW-1:0]  bit_cnt;
  logic [OPW-1:0]   op_q;
  logic [SRW-1:0]   in_sr;
  logic [WORDW-1:0] out_sr;
  logic [LBLAW-1:0] tbl_addr;
  logic             so_bit;

  wire [SRW-1:0] in_next = {in_sr[SRW-2:0], si_s};
  wire [OPW-1:0] op_next = in_next[OPW-1:0];
  wire           op_done = cs_act && sck_rise && (bit_cnt == C_OP_LAST);
  wire           in_data = bit_cnt >= C_DATA0;
  wire [STATW-1:0] status = {{(STATW-3){1'b0}}, fifo_full, fifo_half, fifo_empty};

  // pop handshake completes in the cycle the code is decoded
  assign rx_word_ready = op_done && (op_next == CMD_POP) && rx_word_valid;
  assign lbl_rd_addr   = tbl_addr;
  assign spi_miso      = so_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt      <= '0;
      op_q         <= CMD_NOP;
      in_sr        <= '0;
      out_sr       <= '0;
      tbl_addr     <= '1;
      so_bit       <= 1'b0;
      spi_miso_oe  <= 1'b0;
      lbl_wr_en    <= 1'b0;
      lbl_wr_addr  <= '0;
      lbl_wr_val   <= 1'b0;
      lbl_fill_en  <= 1'b0;
      lbl_fill_val <= 1'b0;
      master_reset <= 1'b0;
      ctrl_reg     <= '0;
      aclk_div     <= '0;
    end else begin
      lbl_wr_en    <= 1'b0;
      lbl_fill_en  <= 1'b0;
      master_reset <= 1'b0;
      spi_miso_oe  <= cs_act;
      if (!cs_act) begin
        bit_cnt <= '0;
        op_q    <= CMD_NOP;
        so_bit  <= 1'b0;
      end else begin
        if (sck_rise) begin
          in_sr <= in_next;
          if (bit_cnt != C_MAX) bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == C_OP_LAST) begin
            op_q     <= op_next;
            tbl_addr <= '1;
            out_sr   <= '0;
            case (op_next)
              CMD_MRESET:     master_reset <= 1'b1;
              CMD_TBL_CLRALL: begin lbl_fill_en <= 1'b1; lbl_fill_val <= 1'b0; end
              CMD_TBL_SETALL: begin lbl_fill_en <= 1'b1; lbl_fill_val <= 1'b1; end
              CMD_POP:        out_sr <= rx_word_valid ? popped : '0;
              CMD_STAT_RD:    out_sr <= {status, {(WORDW-STATW){1'b0}}};
              CMD_CTRL_RD:    out_sr <= {ctrl_reg, {(WORDW-CTRLW){1'b0}}};
              CMD_DIV_RD:     out_sr <= {aclk_div, {(WORDW-DIVW){1'b0}}};
              default:        ;
            endcase
          end else if (in_data) begin
            case (op_q)
              CMD_TBL_CLR1, CMD_TBL_SET1:
                if (bit_cnt == C_ADDR_END) begin
                  lbl_wr_en   <= 1'b1;
                  lbl_wr_addr <= in_next[LBLAW-1:0];
                  lbl_wr_val  <= (op_q == CMD_TBL_SET1);
                end
              CMD_DIV_WR:
                if (bit_cnt == C_DIV_END) aclk_div <= in_next[DIVW-1:0];
              CMD_CTRL_WR:
                if (bit_cnt == C_CTRL_END) ctrl_reg <= in_next[CTRLW-1:0];
              CMD_TBL_BULK:
                if (bit_cnt < C_BULK_END) begin
                  lbl_wr_en   <= 1'b1;
                  lbl_wr_addr <= tbl_addr;
                  lbl_wr_val  <= si_s;
                  tbl_addr    <= tbl_addr - 1'b1;
                end
              default: ;
            endcase
          end
        end
        if (sck_fall && in_data) begin
          if (op_q == CMD_TBL_DUMP) begin
            so_bit   <= lbl_rd_bit;
            tbl_addr <= tbl_addr - 1'b1;
          end else begin
            so_bit <= out_sr[WORDW-1];
            out_sr <= {out_sr[WORDW-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/rxctl_spi_regs_chk.sv
module rxctl_spi_regs_chk #(
  parameter int CTRLW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_miso_oe,
  input logic             rx_word_valid,
  input logic             rx_word_ready,
  input logic             lbl_wr_en,
  input logic             lbl_fill_en,
  input logic             master_reset,
  input logic [CTRLW-1:0] ctrl_reg
);
  logic [3:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             idle_cnt <= '0;
    else if (!spi_cs_n)     idle_cnt <= '0;
    else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
  end

  assert_pop_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_ready |-> rx_word_valid);

  assert_single_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_ready |=> !rx_word_ready);

  assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({master_reset, lbl_fill_en, lbl_wr_en}));

  assert_hiz_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 4'd4) |-> !spi_miso_oe);

  assert_ctrl_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 4'd4) |=> $stable(ctrl_reg));

  assert_no_action_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 4'd4) |-> !(master_reset || lbl_fill_en || lbl_wr_en || rx_word_ready));
endmodule

bind rxctl_spi_regs rxctl_spi_regs_chk #(.CTRLW(CTRLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .rx_word_valid(rx_word_valid), .rx_word_ready(rx_word_ready),
  .lbl_wr_en(lbl_wr_en), .lbl_fill_en(lbl_fill_en),
  .master_reset(master_reset), .ctrl_reg(ctrl_reg)
);

// File: tb/rxctl_spi_regs_test.sv
module rxctl_spi_regs_test;
  localparam int H = 6;
  localparam int NV = 5;
  // {code, write bits, write data, read bits, expected read}
  localparam logic [87:0] VEC [NV] = '{
    {8'h10, 8'd16, 32'h0000_0800, 8'd0,  32'h0},            // R2
    {8'h0B, 8'd0,  32'h0,         8'd16, 32'h0000_0800},    // R2
    {8'h07, 8'd8,  32'h0000_00A5, 8'd0,  32'h0},            // R3
    {8'h0C, 8'd0,  32'h0,         8'd8,  32'h0000_00A5},    // R3
    {8'h0A, 8'd0,  32'h0,         8'd8,  32'h0000_0001}     // R4
  };

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe, rdy, lbl_rd_bit;
  logic wr_en, wr_val, fill_en, fill_val, mrst;
  logic [7:0] rd_addr, wr_addr, div;
  logic [15:0] ctrl;
  logic valid = 0, f_empty = 1, f_half = 0, f_full = 0;
  logic [31:0] wdata = 0;
  logic tbl [256];
  int pops = 0, resets = 0, checks = 0, fails = 0;
  logic oe_mid;
  bit done = 0;

  always #4 clk = ~clk;

  rxctl_spi_regs uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .rx_word_valid(valid),
    .rx_word_ready(rdy), .rx_word_data(wdata), .fifo_empty(f_empty),
    .fifo_half(f_half), .fifo_full(f_full), .lbl_rd_addr(rd_addr),
    .lbl_rd_bit(lbl_rd_bit), .lbl_wr_en(wr_en), .lbl_wr_addr(wr_addr),
    .lbl_wr_val(wr_val), .lbl_fill_en(fill_en), .lbl_fill_val(fill_val),
    .master_reset(mrst), .ctrl_reg(ctrl), .aclk_div(div)
  );

  assign lbl_rd_bit = tbl[rd_addr];

  always @(posedge clk) begin
    if (fill_en) for (int i = 0; i < 256; i++) tbl[i] <= fill_val;
    if (wr_en) tbl[wr_addr] <= wr_val;
    if (rdy && valid) pops <= pops + 1;
    if (mrst) resets <= resets + 1;
  end

  function automatic int ones();
    int n = 0;
    for (int i = 0; i < 256; i++) n += int'(tbl[i]);
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] op, input int nwr, input logic [255:0] wd,
                       input int nrd, output logic [31:0] rd);
    int total;
    total = 8 + ((nwr > nrd) ? nwr : nrd);
    rd = '0;
    cs_n = 0;
    hold(H);
    for (int i = 0; i < total; i++) begin
      if (i < 8) mosi = op[7-i];
      else if (i - 8 < nwr) mosi = wd[nwr-1-(i-8)];
      else mosi = 1'b0;
      hold(H);
      if (i == 8) oe_mid = miso_oe;
      if (i >= 8 && i - 8 < nrd) rd = {rd[30:0], miso};
      sck = 1;
      hold(H);
      sck = 0;
    end
    hold(H);
    cs_n = 1;
    hold(4 * H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int p0, m0;
    for (int i = 0; i < 256; i++) tbl[i] = 1'b0;
    hold(5);
    check("R1 ctrl reset", 32'(ctrl), 32'h0);
    check("R1 div reset", 32'(div), 32'h0);
    check("R1 oe reset", 32'(miso_oe), 32'h0);
    rst_n = 1;
    hold(5);

    for (int v = 0; v < NV; v++) begin
      frame(VEC[v][87:80], int'(VEC[v][79:72]), 256'(VEC[v][71:40]), int'(VEC[v][39:32]), r);
      if (VEC[v][39:32] != 0) check("R2/R3/R4 vector read", r, VEC[v][31:0]);
    end
    check("R2 ctrl port", 32'(ctrl), 32'h0800);
    check("R3 div port", 32'(div), 32'hA5);

    // R4 other flag combination
    f_empty = 0; f_half = 1; f_full = 1;
    frame(8'h0A, 0, 0, 8, r);
    check("R4 status half+full", r, 32'h06);
    check("R14 oe during command", 32'(oe_mid), 32'h1);
    check("R14 oe after command", 32'(miso_oe), 32'h0);

    // R5 pop with label order kept
    wdata = 32'h1234_5601; valid = 1;
    frame(8'h08, 0, 0, 32, r);
    valid = 0;
    check("R5 popped word", r, 32'h1234_5601);
    check("R5 single pop", 32'(pops), 32'd1);

    // R6 reversed label order
    frame(8'h10, 16, 256'h0000, 0, r);
    valid = 1;
    frame(8'h08, 0, 0, 32, r);
    valid = 0;
    check("R6 reversed label", r, 32'h1234_5680);

    // R7 empty pop
    p0 = pops;
    frame(8'h08, 0, 0, 32, r);
    check("R7 empty pop data", r, 32'h0);
    check("R7 empty pop count", 32'(pops), 32'(p0));

    // R8 fills, R9 single entries
    frame(8'h02, 0, 0, 0, r);
    check("R8 clear all", 32'(ones()), 32'd0);
    frame(8'h05, 8, 256'h41, 0, r);
    check("R9 set one entry", 32'(tbl[8'h41]), 32'h1);
    check("R9 set count", 32'(ones()), 32'd1);
    frame(8'h03, 0, 0, 0, r);
    check("R8 set all", 32'(ones()), 32'd256);
    frame(8'h04, 8, 256'h41, 0, r);
    check("R9 clear one entry", 32'(tbl[8'h41]), 32'h0);
    check("R9 clear count", 32'(ones()), 32'd255);

    // R10 bulk write descending, then dump
    frame(8'h06, 256, {4'b1011, 252'b0}, 0, r);
    check("R10 bulk FF", 32'(tbl[8'hFF]), 32'h1);
    check("R10 bulk FE", 32'(tbl[8'hFE]), 32'h0);
    check("R10 bulk FC", 32'(tbl[8'hFC]), 32'h1);
    check("R10 bulk count", 32'(ones()), 32'd3);
    frame(8'h0D, 0, 0, 8, r);
    check("R10 dump top byte", r, 32'hB0);

    // R11 master reset
    frame(8'h10, 16, 256'h0800, 0, r);
    m0 = resets;
    frame(8'h01, 0, 0, 0, r);
    check("R11 reset pulse", 32'(resets), 32'(m0 + 1));
    check("R11 ctrl kept", 32'(ctrl), 32'h0800);

    // R12 aborted writes
    frame(8'h10, 8, 256'hFF, 0, r);
    check("R12 ctrl abort", 32'(ctrl), 32'h0800);
    frame(8'h07, 4, 256'hF, 0, r);
    check("R12 div abort", 32'(div), 32'hA5);
    frame(8'h05, 5, 256'h1F, 0, r);
    check("R12 entry abort", 32'(ones()), 32'd3);

    // R13 inert codes
    p0 = pops; m0 = resets; valid = 1;
    frame(8'h09, 16, 256'hFFFF, 0, r);
    frame(8'h0E, 16, 256'hFFFF, 0, r);
    frame(8'h3F, 16, 256'hFFFF, 0, r);
    frame(8'h00, 16, 256'hFFFF, 0, r);
    valid = 0;
    check("R13 ctrl", 32'(ctrl), 32'h0800);
    check("R13 div", 32'(div), 32'hA5);
    check("R13 pops", 32'(pops), 32'(p0));
    check("R13 resets", 32'(resets), 32'(m0));
    check("R13 table", 32'(ones()), 32'd3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule